// File: doc/BRIEF.md
# Three-Word Recorder Output Sequencer

The sequencer takes 32-bit event words and sends each one to a PC-based recorder over a 16-bit bus. The bus runs in one direction only, and the recorder has no way to push back. Every event becomes a frame of three words: bits 15:0 first, then bits 31:16, then a sync word of all zeros. The zero word lets the receiver find the word order again after a transfer has gone wrong. Because the recorder cannot report that it is busy, the block relies on timing alone. Each word stays on the bus for a fixed number of clock cycles, derived from a clock-frequency parameter and a hold time in microseconds; the default is 20 µs at 80 MHz, which gives 1600 cycles.

Inside each word slot, the active-low write strobe falls only after the data has been stable for a setup interval. The strobe rises again well before the word changes. An active-low request output stays low for the whole frame. It goes high in every cycle in which no frame is being sent.

The block has a one-deep buffer for events that arrive while a frame is in progress. A buffered event is sent right after the current frame ends. An event that arrives when the buffer is already full is discarded, and a sticky dropped-event flag is set. Only reset clears the flag.

Top module: `recorder_sequencer`

## Requirements
- R1: A frame presents three words on the bus in a fixed order: event bits 15:0, then event bits 31:16, then 16'h0000. When an event is accepted in an idle cycle, its lower half appears on the bus in the next cycle.
- R2: Each of the three words stays on the bus for exactly HOLD_CYC = (CLK_HZ / 1,000,000) × HOLD_US consecutive cycles (1600 with the defaults).
- R3: Counting from the first cycle of a word as 0, the write strobe is low (0) exactly in cycles SETUP_CYC to SETUP_CYC+STROBE_CYC−1 of that word. It is high (1) in every other cycle, including all idle cycles.
- R4: The request output is 0 in every cycle of a frame and 1 in every idle cycle. Between two frames there is at least one idle cycle.
- R5: After reset the bus reads 16'h0000, both the request and the write strobe are 1, and the dropped-event flag is 0. While idle, the bus reads 16'h0000.
- R6: An event that arrives during a frame while the buffer is empty is stored. Its frame starts after exactly one idle cycle following the current frame. Changing the event input after an event has been accepted does not change the words being sent.
- R7: An event that arrives during a frame while the buffer is full is discarded: it never appears on the bus. The dropped-event flag becomes 1 and stays 1 until reset.
- R8: An event that arrives in the idle cycle in which a buffered event starts is stored in the buffer and not dropped. It is sent as the frame after the buffered one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event word offered this cycle |
| evt_data | input | 32 | Event word |
| rec_q | output | 16 | Data bus to the recorder |
| rec_req_n | output | 1 | Active-low frame request |
| rec_wr_n | output | 1 | Active-low write strobe |
| drop_flag | output | 1 | Sticky flag: an event was discarded |

## Verification
In one cycle the buffer can both hand its stored event to the frame timer and take in a new event: this happens in the single idle cycle that follows a frame. The bench provokes this by buffering an event during a frame and then offering another event in exactly the gap cycle, where it first checks that the request output is high. It then judges the outcome at the ports. Both frames must follow one after the other in order, each complete and bit-exact. The dropped-event flag must stay 0. A separate case offers a third event while the buffer is full, so the drop path can be contrasted with this collision.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [1:0] {
    W_LOW  = 2'd0,
    W_HIGH = 2'd1,
    W_SYNC = 2'd2
  } word_e;

  // Cycles in a hold interval of 'us' microseconds at 'clk_hz'
  function automatic int unsigned cycles_for_us(int unsigned clk_hz, int unsigned us);
    return (clk_hz / 32'd1_000_000) * us;
  endfunction

  // Bus word for a given slot of the frame
  function automatic logic [15:0] pick_word(logic [31:0] evt, word_e w);
    case (w)
      W_LOW:   return evt[15:0];
      W_HIGH:  return evt[31:16];
      default: return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/rsq_slot_timer.sv
module rsq_slot_timer #(
  parameter int HOLD_CYC   = 1600,
  parameter int SETUP_CYC  = 8,
  parameter int STROBE_CYC = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output rsq_pkg::word_e slot,
  output logic          strobe_on
);
  import rsq_pkg::*;

  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LAST   = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] SU_LO  = CW'(SETUP_CYC);
  localparam logic [CW-1:0] SU_HI  = CW'(SETUP_CYC + STROBE_CYC);

  logic [CW-1:0] cnt;
  logic          slot_end;

  assign slot_end = busy && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      slot <= W_LOW;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
      slot <= W_LOW;
    end else if (slot_end) begin
      cnt <= '0;
      if (slot == W_SYNC) begin
        busy <= 1'b0;
        slot <= W_LOW;
      end else begin
        slot <= word_e'(slot + 2'd1);
      end
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end

  // Strobe window, decoded from registered state only
  assign strobe_on = busy && (cnt >= SU_LO) && (cnt < SU_HI);

endmodule

// File: rtl/rsq_event_buffer.sv
module rsq_event_buffer #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_valid,
  input  logic [DW-1:0] evt_data,
  input  logic          busy,
  output logic          start,
  output logic [DW-1:0] start_data,
  output logic          drop_flag
);
  logic          pend_full;
  logic [DW-1:0] pend_data;

  assign start      = !busy && (pend_full || evt_valid);
  assign start_data = pend_full ? pend_data : evt_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_full <= 1'b0;
      pend_data <= '0;
      drop_flag <= 1'b0;
    end else if (!busy) begin
      if (pend_full) begin
        pend_full <= evt_valid;
        if (evt_valid) pend_data <= evt_data;
      end
    end else if (evt_valid) begin
      if (!pend_full) begin
        pend_full <= 1'b1;
        pend_data <= evt_data;
      end else begin
        drop_flag <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/recorder_sequencer.sv
module recorder_sequencer #(
  parameter int CLK_HZ     = 80_000_000,
  parameter int HOLD_US    = 20,
  parameter int SETUP_CYC  = 8,
  parameter int STROBE_CYC = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        evt_valid,
  input  logic [31:0] evt_data,
  output logic [15:0] rec_q,
  output logic        rec_req_n,
  output logic        rec_wr_n,
  output logic        drop_flag
);
  import rsq_pkg::*;

  localparam int HOLD_CYC = int'(cycles_for_us(CLK_HZ, HOLD_US));

  logic        frame_start;
  logic [31:0] start_data;
  logic        busy;
  word_e       slot;
  logic        strobe_on;
  logic [31:0] frame_word;

  rsq_event_buffer #(.DW(32)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .evt_valid(evt_valid), .evt_data(evt_data),
    .busy(busy),
    .start(frame_start), .start_data(start_data),
    .drop_flag(drop_flag)
  );

  rsq_slot_timer #(
    .HOLD_CYC(HOLD_CYC), .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC)
  ) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .start(frame_start),
    .busy(busy), .slot(slot), .strobe_on(strobe_on)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)           frame_word <= '0;
    else if (frame_start) frame_word <= start_data;
  end

  assign rec_q     = busy ? pick_word(frame_word, slot) : 16'h0000;
  assign rec_req_n = !busy;
  assign rec_wr_n  = !strobe_on;

endmodule

// File: rtl/rsq_checker.sv
module rsq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] q,
  input logic        req_n,
  input logic        wr_n,
  input logic        drop,
  input logic        start
);
  AST_WR_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !req_n); // R3
  AST_DATA_STABLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && $past(!wr_n)) |-> $stable(q)); // R3
  AST_DATA_STABLE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> $stable(q)); // R3
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    req_n |-> (q == 16'h0000)); // R5
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> req_n); // R4
  AST_START_OPENS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !req_n); // R1
  AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> drop); // R7
endmodule

bind recorder_sequencer rsq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .q(rec_q), .req_n(rec_req_n),
  .wr_n(rec_wr_n), .drop(drop_flag), .start(frame_start)
);

// File: tb/recorder_sequencer_test.sv
`timescale 1ns/1ps
module recorder_sequencer_test;
  localparam int CLK_HZ = 1_000_000;
  localparam int HUS    = 20;
  localparam int H      = (CLK_HZ / 1_000_000) * HUS;
  localparam int SU     = 4;
  localparam int ST     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_valid = 1'b0;
  logic [31:0] evt_data = '0;
  logic [15:0] rec_q;
  logic rec_req_n, rec_wr_n, drop_flag;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  recorder_sequencer #(.CLK_HZ(CLK_HZ), .HOLD_US(HUS), .SETUP_CYC(SU), .STROBE_CYC(ST)) uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_data(evt_data),
    .rec_q(rec_q), .rec_req_n(rec_req_n), .rec_wr_n(rec_wr_n), .drop_flag(drop_flag)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Offer one event for one cycle, starting at a negedge; returns at the next negedge
  task automatic offer(logic [31:0] d);
    evt_valid = 1'b1;
    evt_data  = d;
    @(negedge clk);
    evt_valid = 1'b0;
    evt_data  = ~d;
  endtask

  // Called at the negedge of frame cycle 0; returns at the negedge after the frame
  task automatic check_frame(logic [31:0] d, string tag);
    for (int w = 0; w < 3; w++) begin
      int qe = 0, we = 0, re = 0;
      logic [15:0] qa = 0, qx = 0;
      logic wa = 0, wx = 0;
      for (int c = 0; c < H; c++) begin
        logic [15:0] eq;
        logic ew;
        eq = (w == 0) ? d[15:0] : (w == 1) ? d[31:16] : 16'h0000;
        ew = !((c >= SU) && (c < SU + ST));
        if (rec_q !== eq) begin qe++; qa = rec_q; qx = eq; end
        if (rec_wr_n !== ew) begin we++; wa = rec_wr_n; wx = ew; end
        if (rec_req_n !== 1'b0) re++;
        @(negedge clk);
      end
      chk(qe == 0, "R1", $sformatf("%s word %0d data (R2 hold)", tag, w), qa, qx);
      chk(we == 0, "R3", $sformatf("%s word %0d strobe", tag, w), wa, wx);
      chk(re == 0, "R4", $sformatf("%s word %0d request low cycles missed", tag, w), re, 0);
    end
  endtask

  task automatic check_idle(string req, string tag);
    chk(rec_req_n === 1'b1, req, {tag, " request idle"}, rec_req_n, 1);
    chk(rec_q === 16'h0000, "R5", {tag, " idle bus"}, rec_q, 0);
    chk(rec_wr_n === 1'b1, "R3", {tag, " idle strobe"}, rec_wr_n, 1);
  endtask

  task automatic t_reset();
    chk(rec_q === 16'h0000, "R5", "reset bus", rec_q, 0);
    chk(rec_req_n === 1'b1, "R5", "reset request", rec_req_n, 1);
    chk(rec_wr_n === 1'b1, "R5", "reset strobe", rec_wr_n, 1);
    chk(drop_flag === 1'b0, "R5", "reset drop flag", drop_flag, 0);
  endtask

  task automatic t_single(logic [31:0] d);
    offer(d);
    check_frame(d, "single");
    check_idle("R4", "after single");
    repeat (3) @(negedge clk);
    check_idle("R4", "long idle");
  endtask

  task automatic t_back_to_back();
    logic [31:0] a = 32'hA5A5_0F0F, b = 32'h1357_9BDF;
    offer(a);
    fork
      check_frame(a, "b2b first");
      begin repeat (7) @(negedge clk); offer(b); end
    join
    check_idle("R6", "b2b gap");
    @(negedge clk);
    check_frame(b, "R6 buffered");
    check_idle("R4", "after b2b");
    chk(drop_flag === 1'b0, "R6", "no drop on single buffering", drop_flag, 0);
  endtask

  task automatic t_collision();
    logic [31:0] a = 32'h0BAD_F00D, b = 32'hC0FF_EE00, c = 32'h8001_7FFE;
    offer(a);
    fork
      check_frame(a, "coll first");
      begin repeat (H + 3) @(negedge clk); offer(b); end
    join
    check_idle("R8", "coll gap");
    offer(c);
    check_frame(b, "R8 buffered");
    check_idle("R8", "coll second gap");
    @(negedge clk);
    check_frame(c, "R8 restart-cycle arrival");
    chk(drop_flag === 1'b0, "R8", "no drop in restart cycle", drop_flag, 0);
  endtask

  task automatic t_drop();
    logic [31:0] a = 32'h2222_1111, b = 32'h4444_3333, c = 32'h6666_5555;
    offer(a);
    fork
      check_frame(a, "drop first");
      begin repeat (5) @(negedge clk); offer(b); repeat (5) @(negedge clk); offer(c); end
    join
    chk(drop_flag === 1'b1, "R7", "drop flag set", drop_flag, 1);
    check_idle("R4", "drop gap");
    @(negedge clk);
    check_frame(b, "R7 kept");
    check_idle("R7", "dropped event never sent");
    repeat (4 * H) @(negedge clk);
    check_idle("R7", "still idle");
    chk(drop_flag === 1'b1, "R7", "drop flag sticky", drop_flag, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_single(32'h1234_ABCD);
    t_single(32'hFFFF_0000);
    t_single(32'h0001_8000);
    t_back_to_back();
    t_collision();
    t_drop();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(drop_flag === 1'b0, "R7", "reset clears drop flag", drop_flag, 0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule